// File: doc/BRIEF.md
# Generation-Tagged Address-Space Identifier Allocator

This block hands out hardware address-space identifiers (ASIDs) to software contexts when a core switches to a new context. A context ID is a wide tag: the low `ASID_W` bits hold the hardware ASID and the bits above hold a generation number. The allocator keeps the current generation, a bitmap of the ASIDs taken in that generation, and a rolling search position. Each request carries a context ID and the number of the core that is switching. The response is the context ID that core must use from then on, and a flag that tells the core to invalidate its whole local TLB before it runs.

If the request already belongs to the current generation, it comes back unchanged at once. A stale context first tries to keep its old ASID. Otherwise the bitmap is searched, one word per cycle. When no ASID is left, the allocator starts a new generation, empties the bitmap and sets a flush flag for every core. It never refuses a request.

Requests and responses use valid/ready handshakes. A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` is high only while the allocator is idle, so a second request waits until the first response has been taken. A response stays on the port, unchanged, until `rsp_ready` is seen high.

Top module: `asid_gen_alloc`

## Requirements
- R1: After reset `busy` and `rsp_valid` are low and `req_ready` is high. The generation starts at 1 and never takes the value 0. Every response carries the current generation in bits `[CTX_W-1:ASID_W]` and the ASID in bits `[ASID_W-1:0]`.
- R2: A nonzero request whose generation field equals the current generation comes back unchanged. The bitmap and the search position do not change.
- R3: A request equal to zero has never been given an ASID. It always receives a fresh ASID from the search.
- R4: A nonzero request from an older generation whose ASID is nonzero and not yet taken keeps that ASID. The ASID is marked as taken and returned with the current generation. The search position does not change.
- R5: Any other request takes the lowest free ASID that is at or above the search position, up to the top of the range. The search position then moves to that ASID. ASID 0 is never handed out.
- R6: If the search finds no free ASID, the generation advances by one (skipping 0 when it wraps) and the bitmap is cleared. Every core's flush flag is set, the search position returns to 1, and the response is ASID 1 in the new generation.
- R7: `rsp_flush` equals the flush flag of the requesting core. That flag is cleared when the response handshake completes.
- R8: From the cycle after a request is accepted until the response handshake, `busy` is high and `req_ready` is low. A request driven during that time is ignored.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_ctx` and `rsp_flush` hold their values.
- R10: The bitmap is scanned one `WORD_W`-bit word per cycle. `rsp_valid` rises within `NUM_WORDS+1` cycles of the accepting edge, and one cycle after it on the fast path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Allocator idle, request can be taken |
| req_ctx | input | CTX_W | Context ID of the incoming context |
| req_core | input | CORE_W | Number of the switching core |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_ctx | output | CTX_W | Context ID to use from now on |
| rsp_flush | output | 1 | Core must invalidate its local TLB |
| busy | output | 1 | A request is in progress |

## Verification
The assertions check on every cycle the properties that hold at any single step:
- a response always carries the live generation and a nonzero ASID;
- the generation is never zero;
- a held response does not change;
- a new generation marks every core for a flush;
- a completed handshake clears the requester's flag;
- no second request is taken while one is in progress.

Which ASID is chosen, when reuse wins over search, the search position, the exact rollover point and the latency depend on the history of requests. Only the bench's scenarios can show these. The bench compares every response against a software model of the bitmap and the generation over a long mixed stream of requests on a small configuration.

// File: rtl/asid_alloc_pkg.sv
package asid_alloc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_RESP
  } alloc_state_e;
endpackage

// File: rtl/asid_zero_finder.sv
// Returns the lowest clear bit of a word.
module asid_zero_finder #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned POS_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] occ,
  output logic             found,
  output logic [POS_W-1:0] pos
);
  always_comb begin
    found = 1'b0;
    pos   = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (!occ[i]) begin
        found = 1'b1;
        pos   = POS_W'(i);
      end
    end
  end
endmodule

// File: rtl/asid_flush_flags.sv
// One pending-invalidate flag per core.
module asid_flush_flags #(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned CORE_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_all,
  input  logic                 clr,
  input  logic [CORE_W-1:0]    clr_idx,
  output logic [NUM_CORES-1:0] pend
);
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    always_ff @(posedge clk) begin
      if (!rst_n)                                  pend[c] <= 1'b0;
      else if (set_all)                            pend[c] <= 1'b1;
      else if (clr && (clr_idx == CORE_W'(c)))     pend[c] <= 1'b0;
    end
  end

  AST_ROLLOVER_MARKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    set_all |=> (&pend)); // R6
  AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_all) |=> !pend[$past(clr_idx)]); // R7
endmodule

// File: rtl/asid_gen_alloc.sv
module asid_gen_alloc
  import asid_alloc_pkg::*;
#(
  parameter int unsigned ASID_W    = 8,
  parameter int unsigned GEN_W     = 8,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned CTX_W     = GEN_W + ASID_W,
  parameter int unsigned CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CTX_W-1:0]  req_ctx,
  input  logic [CORE_W-1:0] req_core,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [CTX_W-1:0]  rsp_ctx,
  output logic              rsp_flush,
  output logic              busy
);
  localparam int unsigned NUM_ASID  = 1 << ASID_W;
  localparam int unsigned NUM_WORDS = NUM_ASID / WORD_W;
  localparam int unsigned BIT_W     = $clog2(WORD_W);
  localparam int unsigned WIDX_W    = $clog2(NUM_WORDS);
  localparam logic [WIDX_W-1:0]   LAST_WORD = WIDX_W'(NUM_WORDS - 1);
  localparam logic [NUM_ASID-1:0] ONLY_ONE  = NUM_ASID'(2);

  alloc_state_e        state_q;
  logic [GEN_W-1:0]    gen_q;
  logic [NUM_ASID-1:0] used_q;
  logic [ASID_W-1:0]   cur_q;
  logic [WIDX_W-1:0]   word_q;
  logic                first_q;
  logic [CORE_W-1:0]   core_q;
  logic [CTX_W-1:0]    rsp_ctx_q;

  logic [GEN_W-1:0]  req_gen;
  logic [ASID_W-1:0] req_asid;
  logic              accept, is_hit, can_reuse;
  logic [WORD_W-1:0] word_bits, low_mask, occ;
  logic              found;
  logic [BIT_W-1:0]  find_pos;
  logic [ASID_W-1:0] found_asid;
  logic [GEN_W-1:0]  gen_inc, gen_next;
  logic              set_all, clr;
  logic [NUM_CORES-1:0] pend;

  assign req_gen   = req_ctx[CTX_W-1:ASID_W];
  assign req_asid  = req_ctx[ASID_W-1:0];
  assign req_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_ctx   = rsp_ctx_q;
  assign accept    = req_valid && req_ready;
  assign is_hit    = (req_ctx != '0) && (req_gen == gen_q);
  assign can_reuse = (req_ctx != '0) && (req_asid != '0) && !used_q[req_asid];

  // Scan window: current word, with bits below the start position and ASID 0 masked.
  assign word_bits = used_q[{word_q, {BIT_W{1'b0}}} +: WORD_W];
  always_comb begin
    for (int i = 0; i < WORD_W; i++)
      low_mask[i] = first_q && (BIT_W'(i) < cur_q[BIT_W-1:0]);
  end
  assign occ = word_bits | low_mask | {{(WORD_W-1){1'b0}}, (word_q == '0)};

  asid_zero_finder #(.WIDTH(WORD_W), .POS_W(BIT_W)) finder_i (
    .occ   (occ),
    .found (found),
    .pos   (find_pos)
  );
  assign found_asid = {word_q, find_pos};

  assign gen_inc  = gen_q + GEN_W'(1);
  assign gen_next = (gen_inc == '0) ? GEN_W'(1) : gen_inc;
  assign set_all  = (state_q == ST_SCAN) && !found && (word_q == LAST_WORD);
  assign clr      = rsp_valid && rsp_ready;

  asid_flush_flags #(.NUM_CORES(NUM_CORES), .CORE_W(CORE_W)) flags_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_all (set_all),
    .clr     (clr),
    .clr_idx (core_q),
    .pend    (pend)
  );
  assign rsp_flush = pend[core_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      gen_q     <= GEN_W'(1);
      used_q    <= '0;
      cur_q     <= ASID_W'(1);
      word_q    <= '0;
      first_q   <= 1'b0;
      core_q    <= '0;
      rsp_ctx_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          core_q <= req_core;
          if (is_hit) begin
            rsp_ctx_q <= req_ctx;
            state_q   <= ST_RESP;
          end else if (can_reuse) begin
            used_q[req_asid] <= 1'b1;
            rsp_ctx_q        <= {gen_q, req_asid};
            state_q          <= ST_RESP;
          end else begin
            word_q  <= cur_q[ASID_W-1:BIT_W];
            first_q <= 1'b1;
            state_q <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (found) begin
            used_q[found_asid] <= 1'b1;
            cur_q              <= found_asid;
            rsp_ctx_q          <= {gen_q, found_asid};
            state_q            <= ST_RESP;
          end else if (word_q == LAST_WORD) begin
            gen_q     <= gen_next;
            used_q    <= ONLY_ONE;
            cur_q     <= ASID_W'(1);
            rsp_ctx_q <= {gen_next, ASID_W'(1)};
            state_q   <= ST_RESP;
          end else begin
            word_q  <= word_q + WIDX_W'(1);
            first_q <= 1'b0;
          end
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_ctx) && $stable(rsp_flush))); // R9
  AST_NO_ZERO_ASID: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_ctx[ASID_W-1:0] != '0)); // R5
  AST_RSP_LIVE_GEN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_ctx[CTX_W-1:ASID_W] == gen_q)); // R1
  AST_GEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    gen_q != '0); // R6
  AST_STALL_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && !req_ready)); // R8
endmodule

// File: tb/asid_gen_alloc_tb_top.sv
`timescale 1ns/1ps
module asid_gen_alloc_tb_top;
  localparam int AW = 3, GW = 4, WW = 4, NC = 2;
  localparam int CW = AW + GW;
  localparam int NA = 1 << AW;
  localparam int NWORDS = NA / WW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, rsp_valid, rsp_ready = 1'b0, rsp_flush, busy;
  logic [CW-1:0] req_ctx = '0, rsp_ctx;
  logic [0:0]    req_core = '0;

  always #2.5 clk = ~clk;

  asid_gen_alloc #(.ASID_W(AW), .GEN_W(GW), .WORD_W(WW), .NUM_CORES(NC)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ctx(req_ctx), .req_core(req_core), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_ctx(rsp_ctx), .rsp_flush(rsp_flush), .busy(busy)
  );

  int total = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Reference model of the allocator state
  logic [NA-1:0] mmap = '0;
  logic [GW-1:0] mgen = GW'(1);
  int            mcur = 1;
  logic [NC-1:0] mpend = '0;

  task automatic model_step(input logic [CW-1:0] ctx, input int core,
                            output logic [CW-1:0] ectx, output logic ef,
                            output string tag);
    logic [GW-1:0] g;
    logic [AW-1:0] a;
    int hit;
    g = ctx[CW-1:AW];
    a = ctx[AW-1:0];
    if (ctx != 0 && g == mgen) begin
      ectx = ctx; tag = "R2";
    end else if (ctx != 0 && a != 0 && !mmap[a]) begin
      mmap[a] = 1'b1; ectx = {mgen, a}; tag = "R4";
    end else begin
      hit = -1;
      for (int i = mcur; i < NA; i++)
        if (hit < 0 && i != 0 && !mmap[i]) hit = i;
      if (hit >= 0) begin
        mmap[hit] = 1'b1; mcur = hit;
        ectx = {mgen, AW'(hit)};
        tag = (ctx == 0) ? "R3" : "R5";
      end else begin
        mgen = mgen + GW'(1);
        if (mgen == 0) mgen = GW'(1);
        mmap = NA'(2); mpend = '1; mcur = 1;
        ectx = {mgen, AW'(1)}; tag = "R6";
      end
    end
    ef = mpend[core];
    mpend[core] = 1'b0;
  endtask

  task automatic do_req(input logic [CW-1:0] ctx, input int core, input int hold,
                        output logic [CW-1:0] ectx);
    logic ef;
    string tag;
    int lat;
    model_step(ctx, core, ectx, ef, tag);
    @(negedge clk);
    chk(req_ready === 1'b1, "R8", "ready when idle", int'(req_ready), 1);
    req_valid = 1'b1; req_ctx = ctx; req_core = 1'(core);
    @(posedge clk);
    #1;
    req_ctx = CW'(7'h55);          // stray request while busy: must be ignored (R8)
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (!rsp_valid)
        chk(busy && !req_ready, "R8", "stall while busy", int'({busy, req_ready}), 2);
    end while (!rsp_valid && lat < 20);
    req_valid = 1'b0;
    chk(lat <= NWORDS + 1, "R10", "latency", lat, NWORDS + 1);
    chk(rsp_ctx === ectx, tag, "rsp_ctx", int'(rsp_ctx), int'(ectx));
    chk(rsp_flush === ef, "R7", "rsp_flush", int'(rsp_flush), int'(ef));
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_ctx === ectx && rsp_flush === ef, "R9", "hold",
          int'(rsp_ctx), int'(ectx));
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    #1;
    rsp_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [CW-1:0] got;
    logic [CW-1:0] tctx [6];
    logic [15:0]   lfsr;
    int r;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !rsp_valid && req_ready, "R1", "reset state",
        int'({busy, rsp_valid, req_ready}), 1);

    // Fill gen 1: fresh tasks get 1..7 (R3, R5); first result also shows gen starts at 1 (R1)
    for (int k = 0; k < NA - 1; k++) begin
      do_req('0, 0, 0, got);
      chk(got == {GW'(1), AW'(k + 1)}, "R1", "first generation fill", int'(got),
          int'({GW'(1), AW'(k + 1)}));
    end
    do_req({GW'(1), AW'(3)}, 0, 2, got);   // R2 fast path, R9 hold
    do_req('0, 0, 0, got);                 // R6 rollover, flush on core 0
    do_req({GW'(2), AW'(1)}, 1, 0, got);   // R2 with pending flush on core 1 (R7)
    do_req({GW'(2), AW'(1)}, 1, 0, got);   // R7 flag now clear
    do_req({GW'(1), AW'(5)}, 1, 0, got);   // R4 reuse of old ASID
    do_req({GW'(1), AW'(5)}, 0, 1, got);   // R5 taken, search from position

    // Mixed stream sweep
    for (int t = 0; t < 6; t++) tctx[t] = '0;
    lfsr = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r = int'(lfsr);
      if (((r >> 5) % 4) == 0) tctx[r % 6] = '0;
      do_req(tctx[r % 6], (r >> 3) & 1, (r >> 8) % 3, got);
      tctx[r % 6] = got;
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule